// File: doc/BRIEF.md
# Receive Frame Sorter with CRC-32 Check

This block sits behind the word-aligned, already decoded receive path of a serial link. It watches a stream of 32-bit words, each with a flag that marks it as a control (ordered-set) word. It finds where frames begin and end and runs a CRC-32 over each frame body. The first body word, the header, decides the frame's class: a payload frame goes to the data buffer, an acknowledgement frame goes to the acknowledgement buffer, and any other class is thrown away.

Frame words are written into their buffer as they arrive, but a reader cannot see them until the frame closes with a matching CRC and a legal length. A failed frame is removed by moving the write pointer back. Every frame that reaches its end marker leaves a short record in a third buffer. The record gives the class, the length and the check result, so the host can see what arrived and whether it was good. When a buffer cannot hold a maximum-size frame, the whole frame is refused and a counter goes up.

Top module: `rx_frame_sorter`

## Requirements
- R1: After reset all three buffers read as empty (`*_rd_avail` low) and both counters read zero.
- R2: A frame opens on a control word equal to 32'hBCB5_5757 and closes on a control word equal to 32'hBC95_F5F5. Plain words outside a frame are ignored. Control words other than these two are ignored everywhere.
- R3: The check is CRC-32 with polynomial 0x04C11DB7, preset 0xFFFFFFFF and an inverted result. Each body word is fed most significant bit first. The last body word before the closing marker is the received CRC, and the check passes when it equals the computed value over the earlier body words.
- R4: Header bits [31:24] equal to 8'h44 select the data buffer and 8'hC0 selects the acknowledgement buffer. A good frame places all its body words except the CRC word into that buffer, in arrival order, starting with the header.
- R5: A frame whose header class is any other value is discarded without a record, and `unknown_count` rises by one.
- R6: Each closed frame of a known class that was accepted at its header pushes one record: bit 0 is CRC ok, bit 1 is too long, bit 2 is class (0 data, 1 acknowledgement), bits [7:3] are the stored word count excluding the CRC.
- R7: A frame with a CRC mismatch adds no words to any buffer, and its record has bit 0 clear.
- R8: A frame with more than MAX_WORDS (16) words before its CRC adds nothing to any buffer. Its record has bit 1 set and a length of MAX_WORDS+1.
- R9: At the header, if the selected buffer has fewer than MAX_WORDS free entries or the record buffer is full, the whole frame is dropped without a record, and `overflow_count` rises by one.
- R10: An opening marker inside an open frame abandons that frame: it leaves no words and no record. A frame that closes with fewer than two body words also leaves no words and no record.
- R11: Words of a frame are not readable before the cycle after its closing marker is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A word is present this cycle |
| rx_ctrl | input | 1 | The present word is a control word |
| rx_word | input | 32 | Decoded receive word |
| data_rd_en | input | 1 | Pop the head of the data buffer |
| data_rd_word | output | 32 | Head of the data buffer |
| data_rd_avail | output | 1 | Data buffer holds a committed word |
| ack_rd_en | input | 1 | Pop the head of the acknowledgement buffer |
| ack_rd_word | output | 32 | Head of the acknowledgement buffer |
| ack_rd_avail | output | 1 | Acknowledgement buffer holds a committed word |
| info_rd_en | input | 1 | Pop the head of the record buffer |
| info_rd_rec | output | 8 | Head frame record (layout in R6) |
| info_rd_avail | output | 1 | Record buffer is not empty |
| overflow_count | output | 16 | Frames refused for lack of room |
| unknown_count | output | 16 | Frames discarded for an unknown class |

## Verification
The bench sends frames whose length is exactly MAX_WORDS and one word over it. A design that is off by one there would either drop a legal frame or deliver an oversize one. It lets the acknowledgement buffer and the record buffer fill on purpose to hit the room check at the header. It also sends runt frames and an opening marker in the middle of a frame. An unwinding bug would show up as stray words or stray records in the next drain. Frames are stalled mid-body to catch words leaking to the reader before commit. CRC words with a flipped bit catch a checker that compares the wrong word or includes the CRC word in its own sum.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

   typedef enum logic {
      KIND_DATA = 1'b0,
      KIND_ACK  = 1'b1
   } frame_kind_e;

   localparam logic [31:0] CRC_POLY   = 32'h04C1_1DB7;
   localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;

   // Advance the register over one 32-bit word, most significant bit first.
   function automatic logic [31:0] crc32_word(input logic [31:0] c, input logic [31:0] d);
      logic [31:0] r;
      r = c;
      for (int i = 31; i >= 0; i--) begin
         if (r[31] ^ d[i]) r = (r << 1) ^ CRC_POLY;
         else              r = r << 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/rfs_crc_acc.sv
module rfs_crc_acc (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        step,
   input  logic [31:0] word,
   output logic [31:0] crc_q
);
   import rfs_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc_q <= CRC_PRESET;
      else if (start) crc_q <= CRC_PRESET;
      else if (step)  crc_q <= crc32_word(crc_q, word);
   end

endmodule

// File: rtl/rfs_spec_fifo.sv
module rfs_spec_fifo #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH),
   localparam int PW = AW + 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             commit,
   input  logic             rollback,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_avail,
   output logic [PW-1:0]    free_words
);

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $fatal(1, "rfs_spec_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wr_ptr, vis_ptr, rd_ptr;
   logic [PW-1:0]    vis_used;

   assign vis_used   = vis_ptr - rd_ptr;
   assign rd_avail   = (vis_used != '0);
   assign free_words = PW'(DEPTH) - vis_used;
   assign rd_data    = mem[rd_ptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         vis_ptr <= '0;
         rd_ptr  <= '0;
      end else begin
         if (rollback)   wr_ptr <= vis_ptr;
         else if (wr_en) wr_ptr <= wr_ptr + 1'b1;
         if (commit)     vis_ptr <= wr_ptr + PW'(wr_en);
         if (rd_en && rd_avail) rd_ptr <= rd_ptr + 1'b1;
      end
   end

   // R9: the room check upstream must keep every write inside the array
   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (PW'(wr_ptr - rd_ptr) < PW'(DEPTH)));

   // R4: a pop on an empty buffer leaves the read side untouched
   assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_avail) |=> $stable(rd_ptr));

endmodule

// File: rtl/rx_frame_sorter.sv
module rx_frame_sorter #(
   parameter int          DATA_DEPTH = 64,
   parameter int          ACK_DEPTH  = 16,
   parameter int          INFO_DEPTH = 8,
   parameter int          MAX_WORDS  = 16,
   parameter int          CNT_W      = 16,
   parameter logic [31:0] SOF_CODE   = 32'hBCB5_5757,
   parameter logic [31:0] EOF_CODE   = 32'hBC95_F5F5,
   parameter logic [7:0]  DATA_ROUTE = 8'h44,
   parameter logic [7:0]  ACK_ROUTE  = 8'hC0,
   localparam int LEN_W  = $clog2(MAX_WORDS + 2),
   localparam int INFO_W = LEN_W + 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic              rx_ctrl,
   input  logic [31:0]       rx_word,
   input  logic              data_rd_en,
   output logic [31:0]       data_rd_word,
   output logic              data_rd_avail,
   input  logic              ack_rd_en,
   output logic [31:0]       ack_rd_word,
   output logic              ack_rd_avail,
   input  logic              info_rd_en,
   output logic [INFO_W-1:0] info_rd_rec,
   output logic              info_rd_avail,
   output logic [CNT_W-1:0]  overflow_count,
   output logic [CNT_W-1:0]  unknown_count
);
   import rfs_pkg::*;

   localparam int          INFO_FW = $clog2(INFO_DEPTH) + 1;
   localparam logic [LEN_W-1:0] MAX_L  = LEN_W'(MAX_WORDS);
   localparam logic [LEN_W-1:0] MAX_P1 = LEN_W'(MAX_WORDS + 1);

   initial begin
      assert (DATA_DEPTH >= MAX_WORDS && ACK_DEPTH >= MAX_WORDS)
         else $fatal(1, "rx_frame_sorter: each frame buffer must hold MAX_WORDS");
      assert (MAX_WORDS >= 1 && DATA_ROUTE != ACK_ROUTE && SOF_CODE != EOF_CODE)
         else $fatal(1, "rx_frame_sorter: illegal framing parameters");
   end

   // frame tracking state
   logic              in_frame_q, first_q, drop_q;
   frame_kind_e       kind_q;
   logic [LEN_W-1:0]  count_q;
   logic [31:0]       held_q;
   logic [31:0]       crc_q;

   // decode of the incoming word
   logic is_sof, is_eof, is_body, hdr, push;
   logic hdr_data, hdr_ack, hdr_known, room_ok;
   logic close, crc_match, too_long, good, wr_ok, rollback, info_push;
   logic ovf_inc, unk_inc;

   logic [1:0]        buf_wr, buf_commit, buf_rd, buf_avail;
   logic [31:0]       buf_free  [2];
   logic [31:0]       buf_rdata [2];
   logic [INFO_FW-1:0] info_free;
   logic [INFO_W-1:0] info_rec;

   assign is_sof    = rx_valid && rx_ctrl && (rx_word == SOF_CODE);
   assign is_eof    = rx_valid && rx_ctrl && (rx_word == EOF_CODE) && in_frame_q;
   assign is_body   = rx_valid && !rx_ctrl && in_frame_q && !drop_q;
   assign hdr       = is_body && first_q;
   assign push      = is_body && !first_q;

   assign hdr_data  = (rx_word[31:24] == DATA_ROUTE);
   assign hdr_ack   = (rx_word[31:24] == ACK_ROUTE);
   assign hdr_known = hdr_data || hdr_ack;
   assign room_ok   = ((hdr_ack ? buf_free[1] : buf_free[0]) >= 32'(MAX_WORDS))
                      && (info_free != '0);
   assign ovf_inc   = hdr && hdr_known && !room_ok;
   assign unk_inc   = hdr && !hdr_known;

   assign too_long  = (count_q == MAX_P1);
   assign crc_match = (~crc_q == held_q);
   assign close     = is_eof && !drop_q && !first_q && (count_q != '0);
   assign good      = close && crc_match && !too_long;
   assign rollback  = (is_sof && in_frame_q) || (is_eof && !good);
   assign wr_ok     = push && (count_q < MAX_L);
   assign info_push = close;
   assign info_rec  = {count_q, kind_q, too_long, crc_match};

   assign buf_wr     = {wr_ok && (kind_q == KIND_ACK), wr_ok && (kind_q == KIND_DATA)};
   assign buf_commit = {good  && (kind_q == KIND_ACK), good  && (kind_q == KIND_DATA)};
   assign buf_rd     = {ack_rd_en, data_rd_en};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame_q     <= 1'b0;
         first_q        <= 1'b0;
         drop_q         <= 1'b0;
         kind_q         <= KIND_DATA;
         count_q        <= '0;
         held_q         <= '0;
         overflow_count <= '0;
         unknown_count  <= '0;
      end else begin
         if (ovf_inc) overflow_count <= overflow_count + 1'b1;
         if (unk_inc) unknown_count  <= unknown_count + 1'b1;
         if (is_sof) begin
            in_frame_q <= 1'b1;
            first_q    <= 1'b1;
            drop_q     <= 1'b0;
            count_q    <= '0;
         end else if (is_eof) begin
            in_frame_q <= 1'b0;
         end else if (hdr) begin
            if (!hdr_known || !room_ok) begin
               drop_q <= 1'b1;
            end else begin
               kind_q  <= hdr_ack ? KIND_ACK : KIND_DATA;
               held_q  <= rx_word;
               first_q <= 1'b0;
            end
         end else if (push) begin
            held_q <= rx_word;
            if (!too_long) count_q <= count_q + 1'b1;
         end
      end
   end

   rfs_crc_acc u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .start (is_sof),
      .step  (push),
      .word  (held_q),
      .crc_q (crc_q)
   );

   for (genvar k = 0; k < 2; k++) begin : g_buf
      localparam int D  = (k == 0) ? DATA_DEPTH : ACK_DEPTH;
      localparam int FW = $clog2(D) + 1;
      logic [FW-1:0] free_n;
      rfs_spec_fifo #(.WIDTH(32), .DEPTH(D)) u_fifo (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_en      (buf_wr[k]),
         .wr_data    (held_q),
         .commit     (buf_commit[k]),
         .rollback   (rollback),
         .rd_en      (buf_rd[k]),
         .rd_data    (buf_rdata[k]),
         .rd_avail   (buf_avail[k]),
         .free_words (free_n)
      );
      assign buf_free[k] = 32'(free_n);
   end

   rfs_spec_fifo #(.WIDTH(INFO_W), .DEPTH(INFO_DEPTH)) u_info (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (info_push),
      .wr_data    (info_rec),
      .commit     (info_push),
      .rollback   (1'b0),
      .rd_en      (info_rd_en),
      .rd_data    (info_rd_rec),
      .rd_avail   (info_rd_avail),
      .free_words (info_free)
   );

   assign data_rd_word  = buf_rdata[0];
   assign ack_rd_word   = buf_rdata[1];
   assign data_rd_avail = buf_avail[0];
   assign ack_rd_avail  = buf_avail[1];

   // R2: plain words outside a frame never reach a buffer
   assert_ignore_outside_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ctrl && !in_frame_q) |-> (buf_wr == 2'b00));

   // R7: a failed check cannot make an empty data buffer readable
   assert_bad_crc_hidden_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (info_push && !crc_match && !data_rd_avail) |=> !data_rd_avail);

   // R9: refusals are counted one frame at a time
   assert_ovf_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (CNT_W'(overflow_count - $past(overflow_count)) <= CNT_W'(1)));

   // R5: unknown classes are counted one frame at a time
   assert_unk_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (CNT_W'(unknown_count - $past(unknown_count)) <= CNT_W'(1)));

endmodule

// File: tb/rx_frame_sorter_tb.sv
module rx_frame_sorter_tb;

   localparam int DATA_D = 64;
   localparam int ACK_D  = 16;
   localparam int INFO_D = 8;
   localparam int MAXW   = 16;
   localparam logic [31:0] SOF  = 32'hBCB5_5757;
   localparam logic [31:0] EOF  = 32'hBC95_F5F5;
   localparam logic [31:0] IDLE = 32'hBC95_B5B5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0, rx_ctrl = 1'b0;
   logic [31:0] rx_word = '0;
   logic        data_rd_en = 1'b0, ack_rd_en = 1'b0, info_rd_en = 1'b0;
   logic [31:0] data_rd_word, ack_rd_word;
   logic        data_rd_avail, ack_rd_avail, info_rd_avail;
   logic [7:0]  info_rd_rec;
   logic [15:0] overflow_count, unknown_count;

   int checks = 0, errors = 0;
   int exp_ovf = 0, exp_unk = 0;
   logic [31:0] q_data[$], q_ack[$], q_info[$];

   always #4 clk = ~clk;

   rx_frame_sorter u_dut (
      .clk(clk), .rst_n(rst_n),
      .rx_valid(rx_valid), .rx_ctrl(rx_ctrl), .rx_word(rx_word),
      .data_rd_en(data_rd_en), .data_rd_word(data_rd_word), .data_rd_avail(data_rd_avail),
      .ack_rd_en(ack_rd_en), .ack_rd_word(ack_rd_word), .ack_rd_avail(ack_rd_avail),
      .info_rd_en(info_rd_en), .info_rd_rec(info_rd_rec), .info_rd_avail(info_rd_avail),
      .overflow_count(overflow_count), .unknown_count(unknown_count)
   );

   function automatic logic [31:0] ref_crc(input logic [31:0] w[$]);
      logic [31:0] c = 32'hFFFF_FFFF;
      foreach (w[j]) begin
         for (int b = 31; b >= 0; b--) begin
            logic fb = c[31] ^ w[j][b];
            c = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C1_1DB7;
         end
      end
      return ~c;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put(input logic c, input logic [31:0] w);
      @(negedge clk);
      rx_valid = 1'b1; rx_ctrl = c; rx_word = w;
   endtask

   task automatic quiet();
      @(negedge clk);
      rx_valid = 1'b0; rx_ctrl = 1'b0;
   endtask

   task automatic check_counts();
      chk("R5 unknown_count", 32'(unknown_count), 32'(exp_unk));
      chk("R9 overflow_count", 32'(overflow_count), 32'(exp_ovf));
   endtask

   // drain one buffer: 0 data, 1 ack, 2 record
   task automatic drain(input int k);
      logic av;
      logic [31:0] got, want;
      forever begin
         @(negedge clk);
         data_rd_en = 1'b0; ack_rd_en = 1'b0; info_rd_en = 1'b0;
         case (k)
            0:       begin av = data_rd_avail; got = data_rd_word; end
            1:       begin av = ack_rd_avail;  got = ack_rd_word;  end
            default: begin av = info_rd_avail; got = 32'(info_rd_rec); end
         endcase
         if (!av) break;
         if (k == 0 && q_data.size() == 0 || k == 1 && q_ack.size() == 0 ||
             k == 2 && q_info.size() == 0) begin
            chk(k == 2 ? "R6 extra record" : "R4 extra word", got, 32'hxxxx_xxxx);
            errors += (got === 32'hxxxx_xxxx) ? 1 : 0;
         end else begin
            case (k)
               0:       want = q_data.pop_front();
               1:       want = q_ack.pop_front();
               default: want = q_info.pop_front();
            endcase
            chk(k == 2 ? "R6 record" : "R4 word", got, want);
         end
         case (k)
            0:       data_rd_en = 1'b1;
            1:       ack_rd_en  = 1'b1;
            default: info_rd_en = 1'b1;
         endcase
      end
      case (k)
         0:       begin chk("R4 missing data words", 32'(q_data.size()), 0); q_data.delete(); end
         1:       begin chk("R4 missing ack words", 32'(q_ack.size()), 0); q_ack.delete(); end
         default: begin chk("R6 missing records", 32'(q_info.size()), 0); q_info.delete(); end
      endcase
   endtask

   task automatic drain_all();
      drain(0); drain(1); drain(2);
   endtask

   // n payload words (header first), then CRC; optional idle control word
   // after the header and an optional stall at word index pause_at
   task automatic send_frame(input logic [7:0] route, input int n, input bit corrupt,
                             input bit mid_idle, input int pause_at);
      logic [31:0] pl[$];
      logic [31:0] crc;
      bit known, is_ack, good;
      int free, len;
      pl.push_back({route, 24'($urandom)});
      for (int i = 1; i < n; i++) pl.push_back($urandom);
      crc = ref_crc(pl);
      if (corrupt) crc = crc ^ (32'h1 << ($urandom % 32));
      known  = (route == 8'h44) || (route == 8'hC0);
      is_ack = (route == 8'hC0);
      if (!known) exp_unk++;
      else begin
         free = is_ack ? ACK_D - q_ack.size() : DATA_D - q_data.size();
         if (free < MAXW || q_info.size() >= INFO_D) exp_ovf++;
         else begin
            len  = (n > MAXW) ? MAXW + 1 : n;
            good = !corrupt && (n <= MAXW);
            if (good) foreach (pl[i]) begin
               if (is_ack) q_ack.push_back(pl[i]); else q_data.push_back(pl[i]);
            end
            q_info.push_back(32'({5'(len), is_ack, n > MAXW, !corrupt}));
         end
      end
      put(1'b1, SOF);
      foreach (pl[i]) begin
         if (i == pause_at) begin
            quiet();
            chk("R11 data hidden mid-frame", 32'(data_rd_avail), 0);
            chk("R11 record hidden mid-frame", 32'(info_rd_avail), 0);
         end
         put(1'b0, pl[i]);
         if (mid_idle && i == 0) put(1'b1, IDLE);
      end
      put(1'b0, crc);
      put(1'b1, EOF);
      quiet();
      check_counts();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk("R1 data empty", 32'(data_rd_avail), 0);
      chk("R1 ack empty", 32'(ack_rd_avail), 0);
      chk("R1 record empty", 32'(info_rd_avail), 0);
      chk("R1 counters", 32'({overflow_count, unknown_count}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: junk outside frames and stray control words
      put(1'b0, 32'h4400_0001); put(1'b1, IDLE); put(1'b0, 32'hC000_0002); put(1'b1, EOF);
      quiet(); quiet();
      chk("R2 junk ignored data", 32'(data_rd_avail), 0);
      chk("R2 junk ignored record", 32'(info_rd_avail), 0);
      check_counts();

      // R3 R4 R6: good frames of each class, with idle inside one
      send_frame(8'h44, 4, 0, 1, -1); drain_all();
      send_frame(8'hC0, 2, 0, 0, -1); drain_all();
      // R11: stall mid-frame
      send_frame(8'h44, 5, 0, 0, 3);
      chk("R11 data visible after close", 32'(data_rd_avail), 1);
      drain_all();
      // R7: bad CRC
      send_frame(8'h44, 6, 1, 0, -1);
      chk("R7 no data delivered", 32'(data_rd_avail), 0);
      drain_all();
      // R5: unknown class
      send_frame(8'h3A, 3, 0, 0, -1);
      chk("R5 no record", 32'(info_rd_avail), 0);
      drain_all();
      // R8: length boundaries
      send_frame(8'h44, MAXW, 0, 0, -1); drain_all();
      send_frame(8'h44, MAXW + 1, 0, 0, -1);
      chk("R8 oversize no data", 32'(data_rd_avail), 0);
      drain_all();
      send_frame(8'hC0, MAXW + 3, 0, 0, -1); drain_all();

      // R10: runt frame, then a frame abandoned by a new opening marker
      put(1'b1, SOF); put(1'b0, 32'h4400_0077); put(1'b1, EOF); quiet();
      chk("R10 runt no record", 32'(info_rd_avail), 0);
      chk("R10 runt no data", 32'(data_rd_avail), 0);
      put(1'b1, SOF); put(1'b0, 32'h4400_0088); put(1'b0, 32'h1234_5678);
      send_frame(8'h44, 3, 0, 0, -1);
      drain_all();

      // R9: acknowledgement buffer short of room, then record buffer full
      send_frame(8'hC0, 2, 0, 0, -1);
      send_frame(8'hC0, 3, 0, 0, -1);
      drain_all();
      for (int i = 0; i < INFO_D + 1; i++) send_frame(8'h44, 1, 0, 0, -1);
      drain_all();

      // random mix
      for (int f = 0; f < 60; f++) begin
         int r = $urandom % 10;
         logic [7:0] route = (r < 6) ? 8'h44 : (r < 9) ? 8'hC0 : 8'h11;
         send_frame(route, 1 + $urandom % (MAXW + 2), ($urandom % 5) == 0,
                    ($urandom % 4) == 0, -1);
         if ($urandom % 3 != 0) drain_all();
         if ($urandom % 2 == 0) begin put(1'b0, $urandom); put(1'b1, IDLE); quiet(); end
      end
      drain_all();
      check_counts();

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule